// File: doc/BRIEF.md
# Byte-Wide Reprogrammable Memory Mode Decoder

This block models the control logic of a byte-wide, electrically erasable part that drops into a classic EPROM socket. A small internal array holds the bytes. Each cycle the block looks at the chip select, the output gate, the program strobe and two digital flags. One flag stands for a high voltage on the supply pin and the other for a high voltage on address line 9. From these it picks one operating mode: read, output disable, standby, program, chip erase, inhibit or identification. It then drives the byte-wide bus together with a tri-state enable.

A program operation can only turn bits from 1 to 0. The only way back to 1 is a whole-array erase. When the address-9 flag is raised during a normal read, the bus shows a two-byte identification map instead of the array, and address bit 0 picks between the two bytes. A program or erase starts when the clocked logic sees the program strobe fall. Each pulse therefore performs exactly one operation, no matter how long the strobe stays low.

Top module: `mtp_mode_dec`

## Requirements
- R1: With ce_n=0, oe_n=0, vpp_hi=0 and id_hi=0, dq_oe is 1 and dq_out equals the stored byte at addr.
- R2: With ce_n=1, dq_oe is 0 whatever the other inputs are.
- R3: With ce_n=0 and oe_n=1 and vpp_hi=0, dq_oe is 0 and strobe pulses change no byte. With ce_n=0, oe_n=0 and vpp_hi=1, dq_oe is also 0 and pulses change no byte.
- R4: With ce_n=0, oe_n=1, vpp_hi=1 and id_hi=0, a falling edge on pgm_n, taken at the next rising clock, stores (old byte AND dq_in) at addr.
- R5: A program operation never turns a stored 0 into 1.
- R6: With ce_n=0, oe_n=1, vpp_hi=1 and id_hi=1, a falling edge on pgm_n sets every byte to FFh, whatever addr and dq_in hold.
- R7: With ce_n=0, oe_n=0, vpp_hi=0 and id_hi=1, dq_oe is 1. If addr[0]=0, dq_out is BFh. If addr[0]=1, dq_out is A4h, A5h or A6h for DEV_SEL 0, 1 or 2. The other address bits are ignored.
- R8: With ce_n=1 and vpp_hi=1, strobe pulses change no byte.
- R9: Holding pgm_n low for several cycles performs exactly one operation. dq_in changes made while the strobe stays low have no effect.
- R10: After reset every byte reads FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; fills the array with FFh |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| pgm_n | input | 1 | Program/erase strobe, acts on its falling edge |
| vpp_hi | input | 1 | Flag: programming voltage present |
| id_hi | input | 1 | Flag: high voltage on address line 9 |
| addr | input | AW | Byte address |
| dq_in | input | 8 | Data to program |
| dq_out | output | 8 | Data driven toward the bus |
| dq_oe | output | 1 | Tri-state enable for dq_out |

## Verification
Reads are tried first on the erased array and then after programs that carry different bit patterns. Repeated programs to the same byte separate a plain overwrite from the AND-merge rule, because a later FFh must leave the earlier zeros in place. The identification map is read with addr[0] both low and high and with the upper address bits set, which shows whether the map ignores them. Strobe pulses are applied in standby, inhibit, output disable and gated-on-with-voltage; any write in those modes shows up on later reads. A strobe held low while dq_in changes tells edge triggering from level triggering. A final erase with junk address and data shows whether every byte returns to FFh.

// File: rtl/mtp_mode_dec.sv
module mtp_mode_dec #(
  parameter int AW      = 6,
  parameter int DEV_SEL = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          pgm_n,
  input  logic          vpp_hi,
  input  logic          id_hi,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    dq_in,
  output logic [7:0]    dq_out,
  output logic          dq_oe
);
  localparam int DEPTH = 1 << AW;
  localparam logic [7:0] MFR_CODE = 8'hBF;
  localparam logic [7:0] DEV_CODE = (DEV_SEL == 2) ? 8'hA6 :
                                    (DEV_SEL == 1) ? 8'hA5 : 8'hA4;

  typedef enum logic [2:0] {
    M_STBY, M_INH, M_READ, M_ID, M_ODIS, M_PROG, M_ERASE
  } mode_t;

  mode_t      mode;
  logic [7:0] mem [DEPTH];
  logic       pgm_q;
  logic       strobe_fall;
  logic [7:0] cur_byte;

  always_comb begin
    if (ce_n)        mode = vpp_hi ? M_INH : M_STBY;
    else if (vpp_hi) mode = oe_n ? (id_hi ? M_ERASE : M_PROG) : M_ODIS;
    else if (oe_n)   mode = M_ODIS;
    else             mode = id_hi ? M_ID : M_READ;
  end

  assign cur_byte    = mem[addr];
  assign strobe_fall = pgm_q & ~pgm_n;
  assign dq_oe  = (mode == M_READ || mode == M_ID) && !ce_n && !oe_n;
  assign dq_out = (mode == M_ID) ? (addr[0] ? DEV_CODE : MFR_CODE) : cur_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pgm_q <= 1'b1;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else begin
      pgm_q <= pgm_n;
      if (strobe_fall) begin
        if (mode == M_PROG)
          mem[addr] <= cur_byte & dq_in;
        else if (mode == M_ERASE)
          for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      end
    end
  end

  AST_STBY_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !dq_oe); // R2

  AST_ID_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && id_hi) |-> (dq_out == (addr[0] ? DEV_CODE : MFR_CODE))); // R7

  AST_PROG_CLEARS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_fall && !ce_n && oe_n && vpp_hi && !id_hi)
      |=> ((mem[$past(addr)] & ~$past(cur_byte)) == 8'h00)); // R5

  AST_ERASE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_fall && !ce_n && oe_n && vpp_hi && id_hi)
      |=> (mem[0] == 8'hFF && mem[DEPTH-1] == 8'hFF)); // R6

  AST_NO_EDGE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_fall |=> (mem[$past(addr)] == $past(cur_byte))); // R9

  AST_INHIBIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> (mem[$past(addr)] == $past(cur_byte))); // R8
endmodule

// File: tb/mtp_mode_dec_tb.sv
module mtp_mode_dec_tb;
  localparam int AW = 6;

  typedef struct {
    logic       oe;
    logic [7:0] d;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1, vpp_hi = 1'b0, id_hi = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] dq_in = 8'h00;
  logic [7:0] dq_out;
  logic dq_oe;

  int total = 0, bad = 0;
  bit done = 0;
  exp_t q[$];

  always #4 clk = ~clk;

  mtp_mode_dec #(.AW(AW), .DEV_SEL(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
    .vpp_hi(vpp_hi), .id_hi(id_hi), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if (dq_oe !== e.oe || (e.oe && dq_out !== e.d)) begin
        bad++;
        $display("FAIL %s: got oe=%b d=%h, expected oe=%b d=%h",
                 e.tag, dq_oe, dq_out, e.oe, e.d);
      end
    end
  end

  task automatic pins(input logic c, input logic o, input logic v,
                      input logic a9, input logic [AW-1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    ce_n = c; oe_n = o; vpp_hi = v; id_hi = a9; addr = a; dq_in = d;
  endtask

  task automatic expect_bus(input logic oe, input logic [7:0] d, input string tag);
    exp_t e;
    e.oe = oe; e.d = d; e.tag = tag;
    q.push_back(e);
    @(posedge clk); #1;
  endtask

  task automatic pulse(input int low_cycles);
    @(posedge clk); #1; pgm_n = 1'b0;
    repeat (low_cycles) @(posedge clk);
    #1; pgm_n = 1'b1;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [7:0] d, input string tag);
    pins(1'b0, 1'b0, 1'b0, 1'b0, a, 8'h00);
    expect_bus(1'b1, d, tag);
  endtask

  task automatic prog(input logic [AW-1:0] a, input logic [7:0] d);
    pins(1'b0, 1'b1, 1'b1, 1'b0, a, d);
    pulse(1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    expect_bus(1'b0, 8'h00, "R10 standby after reset");
    rd(6'd5,  8'hFF, "R10 erased after reset");
    rd(6'd63, 8'hFF, "R1 read top byte erased");

    prog(6'd5, 8'hA5);
    rd(6'd5, 8'hA5, "R4 program A5");
    prog(6'd5, 8'h0F);
    rd(6'd5, 8'h05, "R4 AND merge");
    prog(6'd5, 8'hFF);
    rd(6'd5, 8'h05, "R5 zeros stay zero");
    prog(6'd9, 8'h3C);
    rd(6'd9, 8'h3C, "R1 read addr 9");
    rd(6'd5, 8'h05, "R1 neighbour untouched");

    pins(1'b0, 1'b0, 1'b0, 1'b1, 6'd0, 8'h00);
    expect_bus(1'b1, 8'hBF, "R7 maker code");
    pins(1'b0, 1'b0, 1'b0, 1'b1, 6'd1, 8'h00);
    expect_bus(1'b1, 8'hA4, "R7 device code");
    pins(1'b0, 1'b0, 1'b0, 1'b1, 6'h3E, 8'h00);
    expect_bus(1'b1, 8'hBF, "R7 upper bits ignored");
    pins(1'b0, 1'b0, 1'b0, 1'b1, 6'h3F, 8'h00);
    expect_bus(1'b1, 8'hA4, "R7 upper bits ignored odd");

    pins(1'b1, 1'b0, 1'b0, 1'b0, 6'd9, 8'h00);
    expect_bus(1'b0, 8'h00, "R2 standby oe low");
    pins(1'b1, 1'b0, 1'b0, 1'b1, 6'd9, 8'h00);
    expect_bus(1'b0, 8'h00, "R2 standby with id flag");
    pins(1'b1, 1'b1, 1'b1, 1'b0, 6'd9, 8'h00);
    expect_bus(1'b0, 8'h00, "R2 inhibit no drive");
    pulse(1);
    rd(6'd9, 8'h3C, "R8 inhibit program");
    pins(1'b1, 1'b1, 1'b1, 1'b1, 6'd9, 8'h00);
    pulse(1);
    rd(6'd9, 8'h3C, "R8 inhibit erase");

    pins(1'b0, 1'b1, 1'b0, 1'b0, 6'd9, 8'h00);
    expect_bus(1'b0, 8'h00, "R3 output disable");
    pulse(1);
    rd(6'd9, 8'h3C, "R3 disable no write");
    pins(1'b0, 1'b0, 1'b1, 1'b0, 6'd9, 8'h00);
    expect_bus(1'b0, 8'h00, "R3 vpp with oe low no drive");
    pulse(1);
    rd(6'd9, 8'h3C, "R3 vpp with oe low no write");

    pins(1'b0, 1'b1, 1'b1, 1'b0, 6'd20, 8'hF0);
    @(posedge clk); #1; pgm_n = 1'b0;
    @(posedge clk); #1; dq_in = 8'h00;
    repeat (4) @(posedge clk);
    #1; pgm_n = 1'b1;
    rd(6'd20, 8'hF0, "R9 one op per pulse");

    pins(1'b0, 1'b1, 1'b1, 1'b1, 6'd7, 8'h00);
    pulse(1);
    rd(6'd5,  8'hFF, "R6 erase addr 5");
    rd(6'd9,  8'hFF, "R6 erase addr 9");
    rd(6'd20, 8'hFF, "R6 erase addr 20");
    prog(6'd63, 8'h5A);
    rd(6'd63, 8'h5A, "R4 program after erase");

    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule